// File: doc/BRIEF.md
# Key-Protected Burst Serial Transmitter

This block is a transmit-only asynchronous serial port that sends a burst of one to six bytes from a single configuration. The payload sits in three 16-bit holding registers, two bytes in each. A small register interface gives access to a control register, two key registers and the three holding registers. The control register accepts a write only after a two-step key unlock. Software unlocks the block, writes the control word with the enable bit and the burst length, and then fills the holding registers. Writing the register that holds the last configured byte starts the burst.

Bit timing comes from an external timer. The timer pulses `bit_tick` once per bit period, and the block does not divide or count time itself. While a burst is pending or in progress, a read-only state field in the control register is nonzero and `tx_busy` is high. When the burst ends, a read of the control register returns the configured value again, so software can poll for completion. The register port has no back-pressure. Every write or read strobe is accepted in the cycle it is presented, and the holding registers are the block's only buffering.

Register addresses on `reg_addr`: 0 control, 1 first key, 2 second key, 3/4/5 holding registers 0/1/2. The key registers read as zero.

Top module: `keyed_burst_tx`

## Requirements
- R1: After reset, `tx_line` is 1 (idle high), `tx_busy` is 0 and the control register reads 0x0000.
- R2: A control write is accepted only after the unlock sequence: 0x76 written to the first key (address 1), then 0xB1 written to the second key (address 2), on back-to-back register accesses. Any read or write strobe is an access. A wrong key value, or any other access between the two key writes, breaks the sequence. A control write without the unlock leaves the control register unchanged.
- R3: One unlock allows exactly one control write. A second control write without a new unlock is ignored.
- R4: Control layout: bit 0 enable; bit 1 reset; bits [4:2] burst-length code (code c means c+1 bytes); bits [8:5] read-only state; bits [15:9] read 0. While idle, a read returns the written bits [4:0], with bit 1 reading 0.
- R5: While a burst is pending or in progress, `tx_busy` is 1 and bits [8:5] hold 1 plus the index (0..5) of the byte being sent. On the tick that ends the burst, `tx_busy` falls and the control register again reads the written value.
- R6: A burst is armed only when four conditions hold: the block is enabled, it is idle, the code is 0..5, and holding register (code/2) is written. A write to any other holding register does not arm the burst. Codes 6 and 7 never arm a burst, and neither does a disabled block.
- R7: Each byte takes 12 bit periods: a start bit 0, eight data bits LSB first, an even-parity bit, and two stop bits of 1. After arming, the line stays high until the next `bit_tick`. Each tick moves the line to the next bit, and the tick after the final stop bit returns the block to idle.
- R8: Bytes are sent in this order: holding 0 bits [7:0], holding 0 bits [15:8], holding 1 low, holding 1 high, holding 2 low, holding 2 high.
- R9: Writes to the holding registers while `tx_busy` is 1 are ignored. Both the readback and the transmitted data stay unchanged.
- R10: An accepted control write during a burst ends the burst. In the next cycle `tx_line` is 1 and `tx_busy` is 0. Writing 0 also disables the block.
- R11: An accepted control write with bit 1 set clears the control register and all holding registers and ends any burst. The control register then reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (counts as an access for unlock) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| bit_tick | input | 1 | One-cycle pulse per bit period from the timer |
| tx_line | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | Burst pending or in progress |

## Verification
The main function is driven with bursts of one, two, four and six bytes. The one-byte burst separates the start, parity and stop positions. The two-byte burst shows whether the high byte of a register follows its low byte. The four-byte burst arms from the middle register. The six-byte burst shows whether all three registers are walked in order and whether the burst ends on the final stop bit. The payloads mix odd and even bit counts, so a wrong parity sense or a swapped data order changes the line at a known tick. Separate directed sequences cover a broken key sequence, a reused unlock, out-of-order register fills, unused length codes, writes during a burst, abort, and soft reset.

// File: rtl/kbt_pkg.sv
package kbt_pkg;
  localparam int ADDR_W     = 3;
  localparam int CNT_W      = 3;
  localparam int STATE_W    = 4;
  localparam int FRAME_BITS = 12;
  localparam int MAX_CODE   = 5;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_KEYA  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_KEYB  = 3'd2;
  localparam int                DATA_BASE = 3;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_WAIT = 2'd1,
    SH_SEND = 2'd2
  } sh_state_e;

  // start bit in [0], data LSB first, even parity, two stop bits on top
  function automatic logic [FRAME_BITS-1:0] make_frame(input logic [7:0] b);
    return {2'b11, ^b, b, 1'b0};
  endfunction
endpackage

// File: rtl/kbt_unlock.sv
module kbt_unlock
  import kbt_pkg::*;
#(
  parameter logic [7:0] KEY_FIRST  = 8'h76,
  parameter logic [7:0] KEY_SECOND = 8'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        key_byte,
  output logic              unlocked,
  output logic              ctrl_we
);
  logic first_seen;
  logic access;
  logic hit_first;
  logic hit_second;
  logic ctrl_access;

  assign access      = reg_wr | reg_rd;
  assign hit_first   = reg_wr && (reg_addr == ADR_KEYA) && (key_byte == KEY_FIRST);
  assign hit_second  = reg_wr && (reg_addr == ADR_KEYB) && (key_byte == KEY_SECOND);
  assign ctrl_access = reg_wr && (reg_addr == ADR_CTRL);
  assign ctrl_we     = ctrl_access && unlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_seen <= 1'b0;
      unlocked   <= 1'b0;
    end else begin
      if (access) begin
        first_seen <= hit_first;
      end
      if (ctrl_access) begin
        unlocked <= 1'b0;
      end else if (first_seen && hit_second) begin
        unlocked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/kbt_regs.sv
module kbt_regs
  import kbt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_DATA = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic                       ctrl_we,
  input  logic                       busy,
  input  logic [STATE_W-1:0]         state_field,
  output logic [4:0]                 ctrl_q,
  output logic [NUM_DATA*DATA_W-1:0] data_flat,
  output logic                       arm,
  output logic                       abort,
  output logic [DATA_W-1:0]          reg_rdata
);
  localparam int BYTES_PER_REG = DATA_W / 8;

  logic             soft_reset;
  logic [CNT_W-1:0] code;
  logic             code_ok;
  int               last_reg;

  assign code       = ctrl_q[4:2];
  assign code_ok    = (int'(code) <= MAX_CODE);
  assign soft_reset = ctrl_we && reg_wdata[1];
  assign abort      = ctrl_we;
  assign last_reg   = int'(code) / BYTES_PER_REG;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      if (reg_wdata[1]) begin
        ctrl_q <= '0;
      end else begin
        ctrl_q <= {reg_wdata[4:2], 1'b0, reg_wdata[0]};
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_DATA; gi++) begin : g_hold
      logic hit;
      assign hit = reg_wr && (int'(reg_addr) == DATA_BASE + gi);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          data_flat[gi*DATA_W +: DATA_W] <= '0;
        end else if (soft_reset) begin
          data_flat[gi*DATA_W +: DATA_W] <= '0;
        end else if (hit && !busy) begin
          data_flat[gi*DATA_W +: DATA_W] <= reg_wdata;
        end
      end
    end
  endgenerate

  assign arm = reg_wr && !busy && ctrl_q[0] && code_ok &&
               (int'(reg_addr) == DATA_BASE + last_reg);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADR_CTRL) begin
      reg_rdata[4:0] = ctrl_q;
      reg_rdata[8:5] = state_field;
    end else begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (int'(reg_addr) == DATA_BASE + i) begin
          reg_rdata = data_flat[i*DATA_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/kbt_shifter.sv
module kbt_shifter
  import kbt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_DATA = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bit_tick,
  input  logic                       arm,
  input  logic                       abort,
  input  logic [CNT_W-1:0]           code,
  input  logic [NUM_DATA*DATA_W-1:0] data_flat,
  output logic                       tx_line,
  output logic                       busy,
  output logic [STATE_W-1:0]         state_field
);
  localparam int MAX_BYTES = NUM_DATA * DATA_W / 8;

  sh_state_e             st;
  logic [CNT_W-1:0]      byte_idx;
  logic [3:0]            bit_idx;
  logic [FRAME_BITS-1:0] frame;
  logic [FRAME_BITS-1:0] next_frame;
  logic [7:0]            next_byte;
  int                    sel;

  always_comb begin
    sel       = (st == SH_WAIT) ? 0 : int'(byte_idx) + 1;
    next_byte = '0;
    for (int i = 0; i < MAX_BYTES; i++) begin
      if (sel == i) next_byte = data_flat[i*8 +: 8];
    end
    next_frame = make_frame(next_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SH_IDLE;
      tx_line  <= 1'b1;
      byte_idx <= '0;
      bit_idx  <= '0;
      frame    <= '1;
    end else if (abort) begin
      st       <= SH_IDLE;
      tx_line  <= 1'b1;
      byte_idx <= '0;
      bit_idx  <= '0;
      frame    <= '1;
    end else begin
      unique case (st)
        SH_IDLE: begin
          if (arm) begin
            st       <= SH_WAIT;
            byte_idx <= '0;
          end
        end
        SH_WAIT: begin
          if (bit_tick) begin
            frame   <= next_frame;
            tx_line <= next_frame[0];
            bit_idx <= '0;
            st      <= SH_SEND;
          end
        end
        SH_SEND: begin
          if (bit_tick) begin
            if (bit_idx == 4'(FRAME_BITS - 1)) begin
              if (byte_idx == code) begin
                st       <= SH_IDLE;
                tx_line  <= 1'b1;
                byte_idx <= '0;
                bit_idx  <= '0;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                frame    <= next_frame;
                tx_line  <= next_frame[0];
                bit_idx  <= '0;
              end
            end else begin
              bit_idx <= bit_idx + 1'b1;
              frame   <= {1'b1, frame[FRAME_BITS-1:1]};
              tx_line <= frame[1];
            end
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign busy        = (st != SH_IDLE);
  assign state_field = busy ? ({1'b0, byte_idx} + 4'd1) : '0;
endmodule

// File: rtl/keyed_burst_tx.sv
module keyed_burst_tx
  import kbt_pkg::*;
#(
  parameter int         DATA_W     = 16,
  parameter int         NUM_DATA   = 3,
  parameter logic [7:0] KEY_FIRST  = 8'h76,
  parameter logic [7:0] KEY_SECOND = 8'hB1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bit_tick,
  output logic              tx_line,
  output logic              tx_busy
);
  logic                       unlocked;
  logic                       ctrl_we;
  logic [4:0]                 ctrl_q;
  logic [NUM_DATA*DATA_W-1:0] data_flat;
  logic                       arm;
  logic                       abort;
  logic [STATE_W-1:0]         state_field;

  kbt_unlock #(
    .KEY_FIRST (KEY_FIRST),
    .KEY_SECOND(KEY_SECOND)
  ) u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .reg_addr(reg_addr),
    .key_byte(reg_wdata[7:0]),
    .unlocked(unlocked),
    .ctrl_we (ctrl_we)
  );

  kbt_regs #(
    .DATA_W  (DATA_W),
    .NUM_DATA(NUM_DATA)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ctrl_we    (ctrl_we),
    .busy       (tx_busy),
    .state_field(state_field),
    .ctrl_q     (ctrl_q),
    .data_flat  (data_flat),
    .arm        (arm),
    .abort      (abort),
    .reg_rdata  (reg_rdata)
  );

  kbt_shifter #(
    .DATA_W  (DATA_W),
    .NUM_DATA(NUM_DATA)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .arm        (arm),
    .abort      (abort),
    .code       (ctrl_q[4:2]),
    .data_flat  (data_flat),
    .tx_line    (tx_line),
    .busy       (tx_busy),
    .state_field(state_field)
  );
endmodule

// File: rtl/kbt_checker.sv
module kbt_checker
  import kbt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_DATA = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic                       tx_line,
  input logic                       tx_busy,
  input logic                       unlocked,
  input logic [4:0]                 ctrl_q,
  input logic [NUM_DATA*DATA_W-1:0] data_flat
);
  logic ctrl_access;
  logic data_access;

  assign ctrl_access = reg_wr && (reg_addr == ADR_CTRL);
  assign data_access = reg_wr && (int'(reg_addr) >= DATA_BASE);

  // R1, R7: an idle block holds the line high
  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  // R2: a locked control write changes nothing
  a_r2_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_access && !unlocked) |=> $stable(ctrl_q));

  // R3: the unlock is spent by one control write
  a_r3_unlock_spent: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_access |=> !unlocked);

  // R7: arming does not drive a start bit before a tick
  a_r7_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> tx_line);

  // R9: holding registers stay frozen during a burst
  a_r9_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && data_access) |=> $stable(data_flat));

  // R6: an unused length code never runs a burst
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> (int'(ctrl_q[4:2]) <= MAX_CODE));

  // R10: an accepted control write ends any burst
  a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_access && unlocked) |=> (!tx_busy && tx_line));
endmodule

bind keyed_burst_tx kbt_checker #(
  .DATA_W  (DATA_W),
  .NUM_DATA(NUM_DATA)
) u_kbt_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .tx_line  (tx_line),
  .tx_busy  (tx_busy),
  .unlocked (unlocked),
  .ctrl_q   (ctrl_q),
  .data_flat(data_flat)
);

// File: tb/test_keyed_burst_tx.sv
module test_keyed_burst_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        bit_tick = 1'b0;
  logic        tx_line;
  logic        tx_busy;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  keyed_burst_tx i_keyed_burst_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .bit_tick (bit_tick),
    .tx_line  (tx_line),
    .tx_busy  (tx_busy)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [15:0] d0;
    logic [15:0] d1;
    logic [15:0] d2;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd0, 16'h00A5, 16'h0000, 16'h0000},
    '{3'd1, 16'h8001, 16'h0000, 16'h0000},
    '{3'd3, 16'h7E13, 16'hC2FF, 16'h0000},
    '{3'd5, 16'h0102, 16'h0380, 16'hF00D}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic unlock();
    wr(3'd1, 16'h0076);
    wr(3'd2, 16'h00B1);
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  function automatic logic [7:0] byte_of(input logic [15:0] d0, d1, d2, input int k);
    logic [15:0] w;
    w = (k < 2) ? d0 : (k < 4) ? d1 : d2;
    return (k % 2 == 0) ? w[7:0] : w[15:8];
  endfunction

  // expects an armed burst; ticks it through and checks every bit
  task automatic run_burst(input logic [2:0] code, input logic [15:0] d0, d1, d2,
                           input logic [15:0] written);
    logic [15:0] v;
    logic [11:0] fr;
    logic [7:0]  b;
    check("R7 line high before first tick", 32'(tx_line), 32'd1);
    for (int k = 0; k <= int'(code); k++) begin
      b  = byte_of(d0, d1, d2, k);
      fr = {2'b11, ^b, b, 1'b0};
      for (int j = 0; j < 12; j++) begin
        tick();
        check("R7 R8 line bit", 32'(tx_line), 32'(fr[j]));
      end
      rd(3'd0, v);
      check("R5 state field", 32'(v[8:5]), 32'(k + 1));
    end
    tick();
    check("R5 busy falls after last stop", 32'(tx_busy), 32'd0);
    check("R7 idle after burst", 32'(tx_line), 32'd1);
    rd(3'd0, v);
    check("R5 readback equals written", 32'(v), 32'(written));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] cw;
    int          last;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 line", 32'(tx_line), 32'd1);
    check("R1 busy", 32'(tx_busy), 32'd0);
    rd(3'd0, v);
    check("R1 control", 32'(v), 32'd0);

    // R2 locked write, broken sequence, wrong key
    wr(3'd0, 16'h0005);
    rd(3'd0, v);
    check("R2 write without unlock", 32'(v), 32'd0);
    wr(3'd1, 16'h0076); rd(3'd4, v); wr(3'd2, 16'h00B1); wr(3'd0, 16'h0005);
    rd(3'd0, v);
    check("R2 interrupted sequence", 32'(v), 32'd0);
    wr(3'd1, 16'h0077); wr(3'd2, 16'h00B1); wr(3'd0, 16'h0005);
    rd(3'd0, v);
    check("R2 wrong first key", 32'(v), 32'd0);

    // R3 one write per unlock; R4 readback layout
    unlock(); wr(3'd0, 16'h0001);
    rd(3'd0, v);
    check("R4 accepted write readback", 32'(v), 32'h0001);
    wr(3'd0, 16'h000D);
    rd(3'd0, v);
    check("R3 second write ignored", 32'(v), 32'h0001);

    // table of bursts
    foreach (VECS[i]) begin
      cw = {11'd0, VECS[i].code, 2'b01};
      unlock(); wr(3'd0, cw | 16'hFE00);
      rd(3'd0, v);
      check("R4 reserved bits read zero", 32'(v), 32'(cw));
      last = int'(VECS[i].code) / 2;
      for (int r = 0; r <= last; r++) begin
        wr(3'(3 + r), (r == 0) ? VECS[i].d0 : (r == 1) ? VECS[i].d1 : VECS[i].d2);
        check("R6 arms on last register only", 32'(tx_busy), (r == last) ? 32'd1 : 32'd0);
      end
      run_burst(VECS[i].code, VECS[i].d0, VECS[i].d1, VECS[i].d2, cw);
    end

    // R9 writes during a burst ignored
    unlock(); wr(3'd0, 16'h0005);
    wr(3'd3, 16'h3C5A);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v);
    check("R9 holding reg unchanged", 32'(v), 32'h3C5A);
    run_burst(3'd1, 16'h3C5A, 16'h0, 16'h0, 16'h0005);

    // R10 abort mid burst
    unlock(); wr(3'd0, 16'h0001);
    wr(3'd3, 16'h1234);
    tick(); tick(); tick();
    check("R10 burst running", 32'(tx_busy), 32'd1);
    unlock(); wr(3'd0, 16'h0000);
    check("R10 busy cleared", 32'(tx_busy), 32'd0);
    check("R10 line idle", 32'(tx_line), 32'd1);
    rd(3'd0, v);
    check("R10 control disabled", 32'(v), 32'd0);

    // R6 out-of-order fill, unused code, disabled
    unlock(); wr(3'd0, 16'h000D);
    wr(3'd3, 16'h1111);
    check("R6 first reg no arm", 32'(tx_busy), 32'd0);
    wr(3'd5, 16'h2222);
    check("R6 third reg no arm", 32'(tx_busy), 32'd0);
    wr(3'd4, 16'h3333);
    check("R6 last reg arms", 32'(tx_busy), 32'd1);
    unlock(); wr(3'd0, 16'h0019);
    check("R10 reconfig stops burst", 32'(tx_busy), 32'd0);
    wr(3'd3, 16'h1); wr(3'd4, 16'h2); wr(3'd5, 16'h3);
    check("R6 code 6 never arms", 32'(tx_busy), 32'd0);
    unlock(); wr(3'd0, 16'h0000);
    wr(3'd3, 16'h0055);
    check("R6 disabled never arms", 32'(tx_busy), 32'd0);

    // R11 soft reset mid burst
    unlock(); wr(3'd0, 16'h0001);
    wr(3'd3, 16'hBEEF);
    tick(); tick();
    unlock(); wr(3'd0, 16'h0003);
    rd(3'd0, v);
    check("R11 control cleared", 32'(v), 32'd0);
    check("R11 busy cleared", 32'(tx_busy), 32'd0);
    check("R11 line idle", 32'(tx_line), 32'd1);
    rd(3'd3, v);
    check("R11 holding cleared", 32'(v), 32'd0);

    // R1 reset during a burst
    unlock(); wr(3'd0, 16'h0001);
    wr(3'd3, 16'h0000);
    tick();
    check("R1 start bit before reset", 32'(tx_line), 32'd0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 line after reset", 32'(tx_line), 32'd1);
    check("R1 busy after reset", 32'(tx_busy), 32'd0);
    rst_n = 1'b1;
    rd(3'd0, v);
    check("R1 control after reset", 32'(v), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule